// File: doc/BRIEF.md
# DMA Channel Completion Interrupt Collector

This block collects the completion events of a multi-channel DMA engine and turns them into one interrupt request for the host processor. Each channel signals the end of a transfer with a single-cycle pulse. The pulse is captured in a sticky per-channel status flag. That flag stays set until software clears it by writing a one to its position in the status register.

A per-channel enable mask selects which captured flags may raise the interrupt. The raw status flags can always be read, whatever the mask holds. A second, read-only view returns only the flags that are both set and enabled. Software can hold the interrupt line low by writing zero to the enable mask, and no captured event is lost while it does so. Writing the mask back later raises the line again. The block also holds one global control flag that selects the 32-bit addressing mode of the engine, and it drives that flag out to the engine.

A two-state machine drives the interrupt line. In IRQ_IDLE the line is low. The ASSERT transition moves it to IRQ_ACTIVE in the cycle after any enabled flag is pending. In IRQ_ACTIVE the line is high. The RELEASE transition returns it to IRQ_IDLE in the cycle after no enabled flag is pending. Register reads are combinational from the current register state.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, the status flags, the enable mask, the control flag and the interrupt line are all zero, and every register reads zero.
- R2: A one-cycle pulse on chan_done[i] sets status bit i at the next clock edge. The bit then holds until software clears it.
- R3: A write to offset 0x080000 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value. Writing all ones clears every channel.
- R4: If a done pulse and a clearing write hit the same status bit in the same cycle, that bit ends up set.
- R5: A read of offset 0x080000 returns status bit i at data bit i, whatever the enable mask holds.
- R6: A read of offset 0x080004 returns the status bits ANDed with the enable bits. Writes to this offset change no register.
- R7: Offset 0x080008 holds the enable mask, bit i for channel i, and can be written and read back. Writing it to zero drops the interrupt without changing any status bit. Restoring it raises the interrupt again.
- R8: irq is high in the cycle after the pending value (status AND enable) is nonzero. It is low in the cycle after the pending value is zero.
- R9: Offset 0x34 holds the address-mode flag in data bit 0, where 1 selects 32-bit addressing. The flag is driven on addr32_mode, and the upper bits of this register read zero.
- R10: Reads of any other offset return zero, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_done | input | NUM_CH | One-cycle completion pulse, one bit per channel |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Level interrupt request, active high |
| addr32_mode | output | 1 | Address-mode flag, 1 selects 32-bit addressing |

## Verification
The bench builds the block with four channels. At that size, every pairing of a 4-bit status pattern with a 4-bit enable mask can be tried, and so can every pairing of a status pattern with a clear mask. The expected pending value, the expected status after a clear and the expected interrupt level are all computed arithmetically. The same-cycle collision of a done pulse with a clear is tried on each channel. The sweeps also cover writes to the read-only pending view and to undecoded offsets.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;

    localparam int OFS_W = 20;
    localparam logic [OFS_W-1:0] OFS_STATUS  = 20'h80000;
    localparam logic [OFS_W-1:0] OFS_PENDING = 20'h80004;
    localparam logic [OFS_W-1:0] OFS_ENABLE  = 20'h80008;
    localparam logic [OFS_W-1:0] OFS_CTRL    = 20'h00034;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_PENDING,
        SEL_ENABLE,
        SEL_CTRL
    } reg_sel_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_ACTIVE
    } irq_state_e;

endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] status_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_o[g] <= 1'b0;
            end else begin
                status_o[g] <= done_i[g] | (status_o[g] & ~clr_i[g]);
            end
        end
    end

    // R2: a pulse always lands in its flag
    p_done_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i != '0) |=> ((status_o & $past(done_i)) == $past(done_i)));

    // R2: no flag rises without a pulse
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i == '0) |=> ((status_o & ~$past(status_o)) == '0));

    // R3: cleared flags without a colliding pulse drop
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~done_i) != '0) |=> ((status_o & $past(clr_i & ~done_i)) == '0));

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_agg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    input  logic [NUM_CH-1:0] status_i,
    output logic [NUM_CH-1:0] clr_o,
    output logic [NUM_CH-1:0] pending_o,
    output logic [31:0]       rdata_o,
    output logic              mode_o
);

    reg_sel_e          sel;
    logic [NUM_CH-1:0] enable_q;
    logic              mode_q;
    logic              unused_ok;

    always_comb begin
        if      (addr_i == ADDR_W'(OFS_STATUS))  sel = SEL_STATUS;
        else if (addr_i == ADDR_W'(OFS_PENDING)) sel = SEL_PENDING;
        else if (addr_i == ADDR_W'(OFS_ENABLE))  sel = SEL_ENABLE;
        else if (addr_i == ADDR_W'(OFS_CTRL))    sel = SEL_CTRL;
        else                                     sel = SEL_NONE;
    end

    assign clr_o     = (we_i && sel == SEL_STATUS) ? wdata_i[NUM_CH-1:0] : '0;
    assign pending_o = status_i & enable_q;
    assign mode_o    = mode_q;
    assign unused_ok = ^wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            mode_q   <= 1'b0;
        end else if (we_i) begin
            if (sel == SEL_ENABLE) enable_q <= wdata_i[NUM_CH-1:0];
            if (sel == SEL_CTRL)   mode_q   <= wdata_i[0];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS:  rdata_o = 32'(status_i);
            SEL_PENDING: rdata_o = 32'(pending_o);
            SEL_ENABLE:  rdata_o = 32'(enable_q);
            SEL_CTRL:    rdata_o = {31'd0, mode_q};
            default:     rdata_o = 32'd0;
        endcase
    end

    // R7: mask only moves on its own write
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && sel == SEL_ENABLE) |=> $stable(enable_q));

    // R9: mode flag only moves on its own write
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && sel == SEL_CTRL) |=> $stable(mode_q));

endmodule

// File: rtl/dma_irq_fsm.sv
module dma_irq_fsm
    import dma_irq_agg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pending_i,
    output logic              irq_o
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending_i != '0) state_d = IRQ_ACTIVE; // ASSERT
            IRQ_ACTIVE: if (pending_i == '0) state_d = IRQ_IDLE;   // RELEASE
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_ACTIVE);
    end

    // R8: line follows pending one cycle later
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i != '0) |=> irq_o);

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i == '0) |=> !irq_o);

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_done,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              addr32_mode
);

    logic [NUM_CH-1:0] status;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] pending;

    initial begin
        assert (NUM_CH >= 1 && NUM_CH <= 32) else $error("NUM_CH out of range");
        assert (ADDR_W >= 20) else $error("ADDR_W too narrow");
    end

    dma_irq_status #(.NUM_CH(NUM_CH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (chan_done),
        .clr_i    (clr),
        .status_o (status)
    );

    dma_irq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr),
        .we_i      (reg_we),
        .wdata_i   (reg_wdata),
        .status_i  (status),
        .clr_o     (clr),
        .pending_o (pending),
        .rdata_o   (reg_rdata),
        .mode_o    (addr32_mode)
    );

    dma_irq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_o     (irq)
    );

    // R4: a colliding pulse wins over the clear
    p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_done & clr) != '0) |=> ((status & $past(chan_done & clr)) == $past(chan_done & clr)));

endmodule

// File: tb/dma_irq_agg_test.sv
module dma_irq_agg_test;

    localparam int PERIOD = 10;
    localparam int NCH    = 4;
    localparam int AW     = 20;
    localparam logic [AW-1:0] A_ST = 20'h80000;
    localparam logic [AW-1:0] A_PD = 20'h80004;
    localparam logic [AW-1:0] A_EN = 20'h80008;
    localparam logic [AW-1:0] A_CT = 20'h00034;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  chan_done = '0;
    logic [AW-1:0]   reg_addr = '0;
    logic            reg_we = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq;
    logic            addr32_mode;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_irq_agg #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
        .clk, .rst_n, .chan_done, .reg_addr, .reg_we, .reg_wdata,
        .reg_rdata, .irq, .addr32_mode
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(negedge clk);
        chan_done = m;
        @(negedge clk);
        chan_done = '0;
    endtask

    initial begin
        #(PERIOD*150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 mode", {31'd0, addr32_mode}, 32'd0);
        rd(A_ST, v); check("R1 status", v, 0);
        rd(A_PD, v); check("R1 pending", v, 0);
        rd(A_EN, v); check("R1 enable", v, 0);
        rd(A_CT, v); check("R1 ctrl", v, 0);

        // R2: each channel pulse sets its own bit and holds
        for (int c = 0; c < NCH; c++) begin
            wr(A_ST, 32'hFFFF_FFFF);
            pulse(NCH'(1 << c));
            repeat (3) @(negedge clk);
            rd(A_ST, v); check("R2 set-and-hold", v, 32'(1 << c));
        end

        // R5 R6 R7 R8: status x enable exhaustive
        for (int s = 0; s < (1 << NCH); s++) begin
            for (int e = 0; e < (1 << NCH); e++) begin
                wr(A_ST, 32'hFFFF_FFFF);
                pulse(NCH'(s));
                wr(A_EN, 32'(e));
                @(negedge clk);
                check("R8 irq level", {31'd0, irq}, {31'd0, ((s & e) != 0)});
                rd(A_ST, v); check("R5 raw status", v, 32'(s));
                rd(A_PD, v); check("R6 pending", v, 32'(s & e));
                rd(A_EN, v); check("R7 enable readback", v, 32'(e));
            end
        end

        // R3: status x clear-mask exhaustive
        wr(A_EN, 32'h0);
        for (int s = 0; s < (1 << NCH); s++) begin
            for (int c = 0; c < (1 << NCH); c++) begin
                wr(A_ST, 32'hFFFF_FFFF);
                pulse(NCH'(s));
                wr(A_ST, 32'(c));
                rd(A_ST, v); check("R3 clear", v, 32'(s & ~c));
            end
        end
        pulse('1);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); check("R3 clear all", v, 0);

        // R4: collision on each channel
        for (int c = 0; c < NCH; c++) begin
            wr(A_ST, 32'hFFFF_FFFF);
            @(negedge clk);
            chan_done = NCH'(1 << c);
            reg_addr = A_ST; reg_wdata = 32'hFFFF_FFFF; reg_we = 1'b1;
            @(negedge clk);
            chan_done = '0; reg_we = 1'b0;
            rd(A_ST, v); check("R4 collision keeps bit", v, 32'(1 << c));
        end

        // R7: mask off drops irq, status kept, restore raises it
        wr(A_ST, 32'hFFFF_FFFF);
        pulse(4'b1010);
        wr(A_EN, 32'hF);
        @(negedge clk);
        check("R7 irq on", {31'd0, irq}, 1);
        wr(A_EN, 32'h0);
        @(negedge clk);
        check("R7 irq masked", {31'd0, irq}, 0);
        rd(A_ST, v); check("R7 status kept", v, 32'hA);
        wr(A_EN, 32'hF);
        @(negedge clk);
        check("R7 irq restored", {31'd0, irq}, 1);

        // R6: writes to pending view are ignored
        wr(A_PD, 32'hFFFF_FFFF);
        rd(A_ST, v); check("R6 write ignored status", v, 32'hA);
        rd(A_EN, v); check("R6 write ignored enable", v, 32'hF);

        // R8: clear drops irq next cycle
        wr(A_ST, 32'hA);
        @(negedge clk);
        check("R8 irq falls", {31'd0, irq}, 0);

        // R9: control flag
        wr(A_CT, 32'hFFFF_FFFF);
        rd(A_CT, v); check("R9 ctrl read", v, 1);
        check("R9 mode out", {31'd0, addr32_mode}, 1);
        wr(A_CT, 32'h0);
        check("R9 mode cleared", {31'd0, addr32_mode}, 0);

        // R10: undecoded offsets
        pulse(4'b0101);
        wr(20'h80010, 32'hFFFF_FFFF);
        wr(20'h00030, 32'hFFFF_FFFF);
        wr(20'h80001, 32'hFFFF_FFFF);
        rd(20'h80010, v); check("R10 undecoded read", v, 0);
        rd(20'h00038, v); check("R10 undecoded read low", v, 0);
        rd(A_ST, v); check("R10 status untouched", v, 32'h5);
        rd(A_EN, v); check("R10 enable untouched", v, 32'hF);
        rd(A_CT, v); check("R10 ctrl untouched", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule